// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block programs an external FPGA from a configuration image that arrives as a byte stream over a valid/ready handshake. A start pulse latches the total image length. The block then discards bytes until it sees the sync byte 0xFF. It checks the four header bytes that follow and extracts the packed configuration length. If the image is long enough to hold that many bytes, it runs the FPGA's slave-serial sequence: it pulses the active-low PROGRAM line, waits for the device to report that its memory is cleared, and then shifts the image out bit by bit on a data line with a slow configuration clock. Shifting starts at the sync byte itself and runs to the end of the image.

Each bit takes four equal write slots. Data is set while the clock is low, the clock is high for two slots, and then low again. After the last bit the block waits a settle interval and samples the device's DONE line. It then reports a result code in a status register. The status register stays valid until the next start pulse. All wait times are parameters counted in clock cycles, and DONE passes through a two-flop synchroniser before any decision uses it.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, and whenever the block is idle, cfg_prog_n is 1, cfg_cclk is 0, cfg_din is 0, in_ready is 0 and busy is 0. After reset, stat_done is 0.
- R2: Input bytes before the first 0xFF are discarded. If image_len bytes are consumed without a 0xFF (including image_len = 0), the run ends with stat_code 1 and PROGRAM is never driven low.
- R3: The first byte after 0xFF must carry 0x2 in bits 7:4, otherwise stat_code is 2. If the image ends before all four header bytes (H0..H3, following 0xFF) have arrived, stat_code is also 2. In both cases PROGRAM is never driven low.
- R4: The configuration byte count is {H0[3:0], H1, H2, H3[7]}, which is the 24-bit bit count {H0[3:0], H1, H2, H3[7:4]} divided by 8. If the 0-based position of 0xFF plus this count exceeds image_len, the run ends with stat_code 3 before PROGRAM is driven. A sum equal to image_len is accepted.
- R5: When the length check passes, cfg_prog_n goes low for at least PROG_LOW_CYC cycles and no cfg_cclk pulse occurs while it is low. The block then waits CLEAR_WAIT_CYC cycles. If the synchronised DONE is then high, the run ends with stat_code 4 and no cfg_cclk pulse is issued.
- R6: After the clear is acknowledged, the bytes from the 0xFF position to image_len-1 go out on cfg_din, MSB first, one bit per cfg_cclk rising edge. Every byte of the image is consumed.
- R7: Each cfg_cclk high phase lasts exactly 2*SLOT_CYC cycles, and cfg_din does not change while cfg_cclk is high.
- R8: in_ready is never high while cfg_cclk is high. A new byte is accepted only after the previous byte's eighth falling edge.
- R9: After the last bit, the block waits SETTLE_WAIT_CYC cycles and samples the synchronised DONE. High gives stat_code 0 and low gives stat_code 5. stat_code never exceeds 5 while stat_done is 1.
- R10: A start pulse while idle clears stat_done and raises busy on the next cycle. A start pulse while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (honoured only while idle) |
| image_len | input | LEN_W | Total image length in bytes, latched at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_ready | output | 1 | Block accepts the byte this cycle |
| cfg_prog_n | output | 1 | PROGRAM line to the FPGA, active low |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Configuration data |
| cfg_done | input | 1 | DONE line from the FPGA, asynchronous |
| busy | output | 1 | A load is in progress |
| stat_done | output | 1 | Result in stat_code is valid |
| stat_code | output | 3 | 0 ok, 1 no sync, 2 bad header, 3 too short, 4 clear not acknowledged, 5 still busy |

## Verification
Images are built with a random count of leading non-sync bytes, random payloads, and byte counts that fall randomly inside or past the image end. This separates the sync search, the nibble-packed count and the length comparison. Directed images cover the following:
- streams with no sync byte at all, and an empty stream;
- a wrong header tag, and headers cut off after two and after three bytes;
- a count that exactly fills the image, and counts one byte over the end or with the top count nibble set;
- a DONE that stays high through the clear, and a DONE that never rises after shifting;
- a second start issued mid-run.

The serial data is captured on every CCLK rising edge and compared bit for bit with the image from the sync byte onward. This catches any error in bit order, replay of the buffered header, or stream hand-off.

// File: rtl/scl_pkg.sv
// Shared types and constants for the serial configuration loader.
package scl_pkg;

    // Controller states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HDR,
        ST_LENCHK,
        ST_PROG,
        ST_CLEAR,
        ST_FEED,
        ST_SHIFT,
        ST_SETTLE
    } scl_state_e;

    // Result codes reported in the status register
    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_NOSYNC  = 3'd1,
        RC_BADHDR  = 3'd2,
        RC_SHORT   = 3'd3,
        RC_NOCLEAR = 3'd4,
        RC_BUSY    = 3'd5
    } scl_code_e;

    localparam int          HDR_BYTES  = 4;
    localparam int          CNT_BYTE_W = 21;
    localparam logic [7:0]  SYNC_BYTE  = 8'hFF;
    localparam logic [3:0]  HDR_TAG    = 4'h2;

endpackage

// File: rtl/scl_sync2.sv
// Two-flop synchroniser for the asynchronous DONE input.
// Assumes the input changes slowly compared with the clock.
module scl_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    // Purpose: move async_in into the clk domain through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/scl_timer.sv
// Down-counting wait timer. A load sets the count. The zero flag rises
// after val further cycles. Assumes loaded values are at least 1.
module scl_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Purpose: load or decrement the wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/scl_shifter.sv
// Serialises one byte MSB first in four equal write slots per bit:
// slot 0 sets data with the clock low, slots 1-2 hold the clock high,
// and slot 3 returns it low. Data changes only at slot 0 boundaries.
// Assumes load is only asserted while active is low.
module scl_shifter #(
    parameter int SLOT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    output logic       cclk,
    output logic       din,
    output logic       active,
    output logic       byte_end
);
    localparam int SC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SLOT_CYC - 1);

    logic            act_q;
    logic [7:0]      sh_q;
    logic            din_q;
    logic [1:0]      ph_q;
    logic [SC_W-1:0] sc_q;
    logic [2:0]      bidx_q;

    // Purpose: step slot counter, phase and bit index; shift the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            sh_q   <= '0;
            din_q  <= 1'b0;
            ph_q   <= '0;
            sc_q   <= '0;
            bidx_q <= '0;
        end else if (load) begin
            act_q  <= 1'b1;
            sh_q   <= byte_in;
            din_q  <= byte_in[7];
            ph_q   <= '0;
            sc_q   <= '0;
            bidx_q <= '0;
        end else if (act_q) begin
            if (sc_q == SC_LAST) begin
                sc_q <= '0;
                if (ph_q == 2'd3) begin
                    ph_q <= '0;
                    if (bidx_q == 3'd7) begin
                        act_q <= 1'b0;
                    end else begin
                        bidx_q <= bidx_q + 1'b1;
                        sh_q   <= {sh_q[6:0], 1'b0};
                        din_q  <= sh_q[6];
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end else begin
                sc_q <= sc_q + 1'b1;
            end
        end
    end

    assign cclk     = act_q && ((ph_q == 2'd1) || (ph_q == 2'd2));
    assign din      = act_q & din_q;
    assign active   = act_q;
    assign byte_end = act_q && (sc_q == SC_LAST) && (ph_q == 2'd3) && (bidx_q == 3'd7);
endmodule

// File: rtl/serial_cfg_loader.sv
// Slave-serial FPGA configuration loader. It finds the sync byte in the
// incoming image, validates and buffers the four header bytes, checks
// the packed length against the image length, pulses PROGRAM, waits for
// the clear, and shifts the sync byte, the buffered header and the rest
// of the stream out. It finishes with a DONE check. Assumes every wait
// parameter is at least 1 and image_len stays stable during a run
// (it is latched at start anyway).
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int LEN_W           = 24,
    parameter int PROG_LOW_CYC    = 16,
    parameter int CLEAR_WAIT_CYC  = 6250000,
    parameter int SETTLE_WAIT_CYC = 12500000,
    parameter int SLOT_CYC        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] image_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             cfg_prog_n,
    output logic             cfg_cclk,
    output logic             cfg_din,
    input  logic             cfg_done,
    output logic             busy,
    output logic             stat_done,
    output logic [2:0]       stat_code
);
    localparam int WAIT_MAX1 = (CLEAR_WAIT_CYC > SETTLE_WAIT_CYC) ? CLEAR_WAIT_CYC : SETTLE_WAIT_CYC;
    localparam int WAIT_MAX  = (WAIT_MAX1 > PROG_LOW_CYC) ? WAIT_MAX1 : PROG_LOW_CYC;
    localparam int TW        = $clog2(WAIT_MAX + 1);
    localparam int SUM_W     = ((LEN_W > CNT_BYTE_W) ? LEN_W : CNT_BYTE_W) + 1;
    localparam logic [2:0] REPLAY_N = 3'(HDR_BYTES + 1);

    scl_state_e       st_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] taken_q;
    logic [LEN_W-1:0] ffpos_q;
    logic [7:0]       hdr_q [HDR_BYTES];
    logic [1:0]       hidx_q;
    logic [2:0]       ridx_q;
    logic             sdone_q;
    logic [2:0]       code_q;

    logic                  done_s;
    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    logic                  tmr_zero;
    logic                  ser_load;
    logic [7:0]            ser_byte;
    logic                  ser_cclk;
    logic                  ser_din;
    logic                  ser_active;
    logic                  ser_end;
    logic                  more;
    logic                  replay_pend;
    logic [7:0]            replay_byte;
    logic [CNT_BYTE_W-1:0] cfg_bytes;
    logic [SUM_W-1:0]      need_len;
    logic                  too_short;
    logic                  rdy;

    scl_sync2 u_done_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cfg_done),
        .sync_out (done_s)
    );

    scl_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    scl_shifter #(.SLOT_CYC(SLOT_CYC)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .byte_in  (ser_byte),
        .cclk     (ser_cclk),
        .din      (ser_din),
        .active   (ser_active),
        .byte_end (ser_end)
    );

    assign more        = (taken_q != len_q);
    assign replay_pend = (ridx_q < REPLAY_N);
    assign cfg_bytes   = {hdr_q[0][3:0], hdr_q[1], hdr_q[2], hdr_q[3][7]};
    assign need_len    = SUM_W'(ffpos_q) + SUM_W'(cfg_bytes);
    assign too_short   = (need_len > SUM_W'(len_q));

    // Purpose: select the buffered byte for the current replay slot
    always_comb begin
        case (ridx_q)
            3'd0:    replay_byte = SYNC_BYTE;
            3'd1:    replay_byte = hdr_q[0];
            3'd2:    replay_byte = hdr_q[1];
            3'd3:    replay_byte = hdr_q[2];
            default: replay_byte = hdr_q[3];
        endcase
    end

    // Purpose: decode handshake, shifter load and timer load per state
    always_comb begin
        rdy      = 1'b0;
        ser_load = 1'b0;
        ser_byte = in_data;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_SCAN, ST_HDR: rdy = more;
            ST_LENCHK: begin
                if (!too_short) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PROG_LOW_CYC);
                end
            end
            ST_PROG: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CLEAR_WAIT_CYC);
                end
            end
            ST_FEED: begin
                if (replay_pend) begin
                    ser_load = 1'b1;
                    ser_byte = replay_byte;
                end else if (more) begin
                    rdy      = 1'b1;
                    ser_load = in_valid;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_WAIT_CYC);
                end
            end
            default: ;
        endcase
    end

    // Purpose: sequence the load and hold the status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            len_q   <= '0;
            taken_q <= '0;
            ffpos_q <= '0;
            hidx_q  <= '0;
            ridx_q  <= '0;
            sdone_q <= 1'b0;
            code_q  <= RC_OK;
            for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q   <= image_len;
                        taken_q <= '0;
                        sdone_q <= 1'b0;
                        code_q  <= RC_OK;
                        st_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (!more) begin
                        st_q    <= ST_IDLE;
                        sdone_q <= 1'b1;
                        code_q  <= RC_NOSYNC;
                    end else if (in_valid) begin
                        taken_q <= taken_q + 1'b1;
                        if (in_data == SYNC_BYTE) begin
                            ffpos_q <= taken_q;
                            hidx_q  <= '0;
                            st_q    <= ST_HDR;
                        end
                    end
                end
                ST_HDR: begin
                    if (!more) begin
                        st_q    <= ST_IDLE;
                        sdone_q <= 1'b1;
                        code_q  <= RC_BADHDR;
                    end else if (in_valid) begin
                        hdr_q[hidx_q] <= in_data;
                        taken_q       <= taken_q + 1'b1;
                        if ((hidx_q == 2'd0) && (in_data[7:4] != HDR_TAG)) begin
                            st_q    <= ST_IDLE;
                            sdone_q <= 1'b1;
                            code_q  <= RC_BADHDR;
                        end else if (hidx_q == 2'd3) begin
                            st_q <= ST_LENCHK;
                        end else begin
                            hidx_q <= hidx_q + 1'b1;
                        end
                    end
                end
                ST_LENCHK: begin
                    if (too_short) begin
                        st_q    <= ST_IDLE;
                        sdone_q <= 1'b1;
                        code_q  <= RC_SHORT;
                    end else begin
                        st_q <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (tmr_zero) st_q <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    if (tmr_zero) begin
                        if (done_s) begin
                            st_q    <= ST_IDLE;
                            sdone_q <= 1'b1;
                            code_q  <= RC_NOCLEAR;
                        end else begin
                            ridx_q <= '0;
                            st_q   <= ST_FEED;
                        end
                    end
                end
                ST_FEED: begin
                    if (replay_pend) begin
                        ridx_q <= ridx_q + 1'b1;
                        st_q   <= ST_SHIFT;
                    end else if (more) begin
                        if (in_valid) begin
                            taken_q <= taken_q + 1'b1;
                            st_q    <= ST_SHIFT;
                        end
                    end else begin
                        st_q <= ST_SETTLE;
                    end
                end
                ST_SHIFT: begin
                    if (ser_end) st_q <= ST_FEED;
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        st_q    <= ST_IDLE;
                        sdone_q <= 1'b1;
                        code_q  <= done_s ? RC_OK : RC_BUSY;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready   = rdy;
    assign cfg_prog_n = (st_q != ST_PROG);
    assign cfg_cclk   = ser_cclk;
    assign cfg_din    = ser_din & ser_active;
    assign busy       = (st_q != ST_IDLE);
    assign stat_done  = sdone_q;
    assign stat_code  = code_q;
endmodule

// File: rtl/scl_checker.sv
// Port-level properties of the serial configuration loader, bound to
// the top module.
module scl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       in_ready,
    input logic       cfg_prog_n,
    input logic       cfg_cclk,
    input logic       cfg_din,
    input logic       stat_done,
    input logic [2:0] stat_code
);
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready));

    assert_no_clk_in_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> !cfg_cclk);

    assert_din_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));

    assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cfg_cclk);

    assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> (stat_code <= 3'd5));

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !stat_done));
endmodule

bind serial_cfg_loader scl_checker u_scl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .in_ready   (in_ready),
    .cfg_prog_n (cfg_prog_n),
    .cfg_cclk   (cfg_cclk),
    .cfg_din    (cfg_din),
    .stat_done  (stat_done),
    .stat_code  (stat_code)
);

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
    localparam int LEN_W = 16;
    localparam int PL    = 3;
    localparam int CW    = 20;
    localparam int SW    = 30;
    localparam int SLOT  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] image_len = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             cfg_prog_n, cfg_cclk, cfg_din;
    logic             cfg_done = 1'b1;
    logic             busy, stat_done;
    logic [2:0]       stat_code;

    always #4 clk = ~clk;

    serial_cfg_loader #(
        .LEN_W(LEN_W), .PROG_LOW_CYC(PL), .CLEAR_WAIT_CYC(CW),
        .SETTLE_WAIT_CYC(SW), .SLOT_CYC(SLOT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .image_len(image_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .busy(busy), .stat_done(stat_done),
        .stat_code(stat_code)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] img [64];
    int  feed_len = 0;
    int  fidx = 0;
    bit  feeding = 0;
    bit  xfer = 0;

    // monitor state
    bit  cap [512];
    int  ncap = 0;
    int  exp_bits = 0;
    int  hi_len = 0, hi_bad = 0, din_bad = 0, rdy_bad = 0, prog_cnt = 0;
    bit  cclk_d = 0, din_d = 0;
    bit  clear_fail = 0, busy_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // byte handshake bookkeeping
    always @(posedge clk) xfer <= in_valid && in_ready;

    // stream driver with random gaps
    always @(negedge clk) begin
        if (xfer) fidx++;
        if (feeding && fidx < feed_len && fidx < 64) begin
            in_valid = ($urandom_range(0, 3) != 0);
            in_data  = img[fidx];
        end else begin
            in_valid = 1'b0;
            in_data  = 8'h00;
        end
    end

    // serial capture and FPGA DONE model
    always @(negedge clk) begin
        if (cfg_cclk && !cclk_d && ncap < 512) begin
            cap[ncap] = cfg_din;
            ncap++;
        end
        if (cfg_cclk && cclk_d && (cfg_din != din_d)) din_bad++;
        if (cfg_cclk) hi_len++;
        else if (cclk_d) begin
            if (hi_len != 2 * SLOT) hi_bad++;
            hi_len = 0;
        end
        if (in_ready && cfg_cclk) rdy_bad++;
        if (!cfg_prog_n) begin
            prog_cnt++;
            cfg_done = clear_fail;
        end else if (exp_bits > 0 && ncap == exp_bits && !busy_fail && prog_cnt > 0) begin
            cfg_done = 1'b1;
        end
        cclk_d = cfg_cclk;
        din_d  = cfg_din;
    end

    function automatic int exp_code(input int len, input bit cf, input bit bf,
                                    output int ffp);
        int nb;
        ffp = -1;
        for (int i = 0; i < len; i++) begin
            if (img[i] == 8'hFF) begin
                ffp = i;
                break;
            end
        end
        if (ffp < 0) return 1;
        if (ffp + 1 >= len) return 2;
        if (img[ffp+1][7:4] != 4'h2) return 2;
        if (ffp + 4 >= len) return 2;
        nb = int'({img[ffp+1][3:0], img[ffp+2], img[ffp+3], img[ffp+4][7]});
        if (ffp + nb > len) return 3;
        if (cf) return 4;
        if (bf) return 5;
        return 0;
    endfunction

    function automatic string req_of(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic build_img(input int pre, input int tot, input bit bad,
                             input int nb, input int low);
        logic [20:0] n;
        n = 21'(nb);
        for (int i = 0; i < 64; i++) img[i] = 8'($urandom_range(0, 255));
        for (int i = 0; i < pre; i++) img[i] = 8'($urandom_range(0, 254));
        img[pre]   = 8'hFF;
        img[pre+1] = {(bad ? 4'h5 : 4'h2), n[20:17]};
        img[pre+2] = n[16:9];
        img[pre+3] = n[8:1];
        img[pre+4] = {n[0], 3'(low), 4'($urandom_range(0, 15))};
        if (tot < 0) tot = 0;
    endtask

    task automatic run_case(input int len, input bit cf, input bit bf, input bit poke);
        int ffp, ec, t, bad;
        ec = exp_code(len, cf, bf, ffp);
        @(negedge clk); #1;
        ncap = 0; hi_len = 0; hi_bad = 0; din_bad = 0; rdy_bad = 0; prog_cnt = 0;
        clear_fail = cf; busy_fail = bf;
        exp_bits = (ec == 0 || ec == 5) ? 8 * (len - ffp) : -1;
        fidx = 0; feed_len = len; feeding = 1;
        image_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        chk(busy && !stat_done, "R10", "status cleared and busy after start",
            int'({busy, stat_done}), 2);
        #1 start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            #1 start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        t = 0;
        while (busy && t < 30000) begin
            @(negedge clk);
            t++;
        end
        #1 feeding = 0;
        chk(stat_done, req_of(ec), "run finished", int'(stat_done), 1);
        chk(int'(stat_code) == ec, req_of(ec), "result code", int'(stat_code), ec);
        if (ec >= 1 && ec <= 3)
            chk(prog_cnt == 0, (ec == 3) ? "R4" : req_of(ec), "PROGRAM untouched", prog_cnt, 0);
        else
            chk(prog_cnt >= PL, "R5", "PROGRAM low cycles", prog_cnt, PL);
        if (ec == 4) chk(ncap == 0, "R5", "no CCLK after failed clear", ncap, 0);
        if (ec == 0 || ec == 5) begin
            bad = 0;
            for (int k = 0; k < exp_bits && k < 512; k++)
                if (cap[k] != img[ffp + k / 8][7 - (k % 8)]) bad++;
            chk(ncap == exp_bits, "R6", "captured bit count", ncap, exp_bits);
            chk(bad == 0, "R6", "bit mismatches", bad, 0);
            chk(fidx == len, "R6", "bytes consumed", fidx, len);
        end
        chk(hi_bad == 0 && din_bad == 0, "R7", "CCLK width / DIN stability faults",
            hi_bad + din_bad, 0);
        chk(rdy_bad == 0, "R8", "ready during CCLK high", rdy_bad, 0);
        chk(!busy && cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready, "R1",
            "idle levels after run",
            int'({busy, cfg_prog_n, cfg_cclk, cfg_din, in_ready}), 5'b01000);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready && !busy && !stat_done,
            "R1", "reset levels",
            int'({cfg_prog_n, cfg_cclk, cfg_din, in_ready, busy, stat_done}), 6'b100000);

        // R2: no sync byte, and empty image
        for (int i = 0; i < 64; i++) img[i] = 8'($urandom_range(0, 254));
        run_case(9, 0, 0, 0);
        run_case(0, 0, 0, 0);

        // R3: wrong tag, and header cut after two and three bytes
        build_img(2, 20, 1, 10, 0);
        run_case(20, 0, 0, 0);
        build_img(2, 20, 0, 10, 0);
        run_case(5, 0, 0, 0);
        run_case(6, 0, 0, 0);

        // R4: exact fit passes, one over fails, top count nibble set fails
        build_img(3, 24, 0, 21, 5);
        run_case(24, 0, 0, 0);
        build_img(3, 24, 0, 22, 0);
        run_case(24, 0, 0, 0);
        build_img(1, 12, 0, 21'h100000, 0);
        run_case(12, 0, 0, 0);

        // R5: DONE stays high through clear
        build_img(0, 10, 0, 6, 0);
        run_case(10, 1, 0, 0);

        // R9: DONE never rises
        build_img(1, 10, 0, 4, 0);
        run_case(10, 0, 1, 0);

        // R10: second start mid-run ignored
        build_img(2, 14, 0, 12, 0);
        run_case(14, 0, 0, 1);

        // random images
        for (int r = 0; r < 14; r++) begin
            int pre, tot, slack, nb, sel;
            pre   = $urandom_range(0, 4);
            tot   = pre + $urandom_range(5, 30);
            slack = tot - pre;
            sel   = $urandom_range(0, 9);
            nb    = (sel < 7) ? slack - $urandom_range(0, slack) : slack + $urandom_range(1, 5);
            build_img(pre, tot, ($urandom_range(0, 7) == 0), nb, $urandom_range(0, 7));
            run_case(tot, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule